// File: doc/BRIEF.md
# Byte-Framed SPI Master with Decoded Device Selects

This block is an SPI master driven from a simple register write/read port. One control register sets the serial clock's resting level, the clock edge on which incoming data is captured, the frame length (one to four bytes), and whether the device selects are driven by the transfer engine or held directly by software. Four byte-wide data registers hold the outgoing word. Writing the top data byte launches a frame. When the frame ends, the bits shifted in from the slave have replaced the bytes that were sent.

A three-bit select code is decoded onto seven active-low device-select lines. Code zero selects nothing. In automatic mode, the chosen line is pulled low for the duration of a frame only. In manual mode, the line follows the code on every cycle, whether or not a frame is running. The serial clock toggles every `CLK_DIV/2` system clocks. A busy indication is available both as a pin and as a status register bit.

Top module: `spi_sel_master`

## Requirements
- R1: After reset the control register and all four data bytes read 0x00, the status register reads 0x00, `busy` is 0, `sclk` is 0, `mosi` is 0 and all seven `csN` lines are 1.
- R2: Address 0 is the control register. It reads back exactly the last value written. Its fields are: bit 7 clock idle level, bit 6 capture edge, bits 5:4 length code, bit 3 select mode, bits 2:0 select code.
- R3: Outside a frame, `sclk` equals control bit 7 (0 rests low, 1 rests high). After every frame, `sclk` returns to that level.
- R4: Length code 00, 01, 10 and 11 gives a frame of N = 8, 16, 24 and 32 bits. Each frame makes exactly 2N `sclk` transitions, in both select modes.
- R5: `mosi` sends bit N-1 first, then the lower bits in order. The bits come from the word {byte3, byte2, byte1, byte0}, where data byte k sits at address 1+k. Bytes at or above index N/8 are not sent.
- R6: Control bit 6 = 0 captures `miso` on rising `sclk` edges, and 1 captures on falling edges. At the end of the frame, the N captured bits replace data bytes 0 to N/8-1. Higher bytes keep their contents.
- R7: A write to address 4 (data byte 3) while idle starts a frame. `busy` and status bit 0 (address 5) read 1 from the next cycle, for (2N+1)*CLK_DIV/2 cycles.
- R8: While `busy` is 1, writes to any data byte are ignored, and a write to address 4 does not restart or lengthen the frame.
- R9: With control bit 3 = 0, select code k (1 to 7) drives `csN[k-1]` low only while `busy` is 1. The first `sclk` transition comes CLK_DIV/2 cycles after `busy` rises. Code 0 leaves every line high.
- R10: With control bit 3 = 1, `csN[k-1]` is low exactly when the select field holds k. This holds on every cycle, regardless of frames. At most one `csN` line is ever low.
- R11: Successive `sclk` transitions within a frame are CLK_DIV/2 system clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `addr`, combinational |
| busy | output | 1 | High while a frame is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 7 | Active-low device selects, line k-1 for code k |

## Verification
The bench builds the block with its defaults: CLK_DIV = 4, which gives a two-cycle half period. At that rate a full 32-bit frame completes in 130 cycles, so every length code can be run under all four pairings of idle level and capture edge. Every select code, including the empty one, can also be covered in a short run. A behavioural slave answers on the opposite edge to the capture edge. This makes the data exchanged in both directions, the edge spacing, and the select window around the first and last edges all observable at the pins.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  localparam int CTRL_W     = 8;
  localparam int DATA_BYTES = 4;
  localparam int MAX_BITS   = DATA_BYTES * 8;
  localparam int SEL_W      = 3;
  localparam int NUM_CS     = (1 << SEL_W) - 1;
  localparam int LEN_W      = 2;
  localparam int ADDR_W     = 3;

  // control register field positions
  localparam int POS_CPOL  = 7;
  localparam int POS_SFALL = 6;
  localparam int POS_LEN   = 4;
  localparam int POS_MAN   = 3;
  localparam int POS_SEL   = 0;

  // register addresses
  localparam int A_CTRL_I  = 0;
  localparam int A_DATA0_I = 1;
  localparam int A_STAT_I  = A_DATA0_I + DATA_BYTES;
  localparam int A_TOP_I   = A_DATA0_I + DATA_BYTES - 1;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(A_CTRL_I);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(A_STAT_I);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(A_TOP_I);

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic             load;
    logic             sample;
    logic             shift;
    logic             commit;
    logic [LEN_W-1:0] lenCode;
  } xfer_strb_t;

endpackage

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
  import spi_fm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output xfer_strb_t        strb
);

  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGE_W = $clog2(2 * MAX_BITS + 1);

  logic [CTRL_W-1:0] ctrlQ;
  logic              active;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              sclkQ;
  logic              cfgCpol;
  logic              cfgSfall;
  logic [LEN_W-1:0]  cfgLen;
  logic [SEL_W-1:0]  cfgSel;

  logic              startReq;
  logic              ctrlWr;
  logic              tick;
  logic              lastTick;
  logic              toggle;
  logic              leadSample;
  logic              sampleEdge;
  logic              shiftEdge;
  logic [EDGE_W-1:0] frameEdges;
  logic [SEL_W-1:0]  selCode;
  logic              selOn;

  assign startReq   = wrEn && (addr == A_TOP) && !active;
  assign ctrlWr     = wrEn && (addr == A_CTRL);
  assign tick       = active && (divCnt == DIV_W'(HALF - 1));
  assign frameEdges = EDGE_W'({1'b0, cfgLen} + 3'd1) << 4;
  assign lastTick   = tick && (edgeCnt == frameEdges);
  assign toggle     = tick && !lastTick;

  // leading edge captures when it moves sclk toward the capture level
  assign leadSample = (cfgCpol == cfgSfall);
  assign sampleEdge = toggle && (edgeCnt[0] != leadSample);
  assign shiftEdge  = toggle && (edgeCnt[0] == leadSample) && (edgeCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      active   <= 1'b0;
      divCnt   <= '0;
      edgeCnt  <= '0;
      sclkQ    <= 1'b0;
      cfgCpol  <= 1'b0;
      cfgSfall <= 1'b0;
      cfgLen   <= '0;
      cfgSel   <= '0;
    end else begin
      if (ctrlWr) begin
        ctrlQ <= wrData;
      end
      if (startReq) begin
        active   <= 1'b1;
        divCnt   <= '0;
        edgeCnt  <= '0;
        sclkQ    <= ctrlQ[POS_CPOL];
        cfgCpol  <= ctrlQ[POS_CPOL];
        cfgSfall <= ctrlQ[POS_SFALL];
        cfgLen   <= ctrlQ[POS_LEN +: LEN_W];
        cfgSel   <= ctrlQ[POS_SEL +: SEL_W];
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          if (lastTick) begin
            active <= 1'b0;
          end else begin
            sclkQ   <= ~sclkQ;
            edgeCnt <= edgeCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  // select decode: manual follows the live field, automatic uses the frame copy
  assign selCode = ctrlQ[POS_MAN] ? ctrlQ[POS_SEL +: SEL_W] : cfgSel;
  assign selOn   = ctrlQ[POS_MAN] || active;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_csdec
    assign csN[k] = !(selOn && (selCode == SEL_W'(k + 1)));
  end

  assign sclk         = active ? sclkQ : ctrlQ[POS_CPOL];
  assign busy         = active;
  assign ctrlReg      = ctrlQ;
  assign strb.load    = startReq;
  assign strb.sample  = sampleEdge;
  assign strb.shift   = shiftEdge;
  assign strb.commit  = lastTick;
  assign strb.lenCode = active ? cfgLen : ctrlQ[POS_LEN +: LEN_W];

  // R7: a frame only begins after a write to the top data byte
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(wrEn && (addr == A_TOP)));

  // R3: an even number of transitions brings sclk back to its resting level
  p_sclk_home_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> (sclkQ == cfgCpol));

  if (HALF > 1) begin : g_hold
    // R11: no two sclk transitions on adjacent cycles
    p_sclk_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
      (active && $past(active) && (sclkQ != $past(sclkQ))) |=> $stable(sclkQ));
  end

endmodule

// File: rtl/spi_fm_dpath.sv
module spi_fm_dpath
  import spi_fm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wrData,
  input  logic                busy,
  input  xfer_strb_t          strb,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] dataWord
);

  logic [7:0]          dataQ [DATA_BYTES];
  logic [MAX_BITS-1:0] loadWord;
  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;
  logic [LEN_W+2:0]    shiftAmt;

  // the starting write lands in the top byte on the same edge, so take it from the bus
  for (genvar k = 0; k < DATA_BYTES - 1; k++) begin : g_load
    assign loadWord[8*k +: 8] = dataQ[k];
  end
  assign loadWord[MAX_BITS-1 -: 8] = wrData;

  // left-align the frame so its top bit sits at the shifter MSB
  assign shiftAmt = {LEN_W'(DATA_BYTES - 1) - strb.lenCode, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.load) begin
      txShift <= loadWord << shiftAmt;
    end else if (strb.shift) begin
      txShift <= txShift << 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.sample) begin
      rxShift <= {rxShift[MAX_BITS-2:0], miso};
    end
  end

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
    localparam logic [LEN_W:0] BYTE_IDX = (LEN_W + 1)'(k);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ[k] <= '0;
      end else if (!busy && wrEn && (addr == ADDR_W'(A_DATA0_I + k))) begin
        dataQ[k] <= wrData;
      end else if (strb.commit && ({1'b0, strb.lenCode} >= BYTE_IDX)) begin
        dataQ[k] <= rxShift[8*k +: 8];
      end
    end
    assign dataWord[8*k +: 8] = dataQ[k];
  end

  assign mosi = txShift[MAX_BITS-1];

  // R8: during a frame the data bytes move only at the final commit
  p_data_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> $stable(dataWord));

  // R5: the outgoing line changes only on a shift strobe while a frame runs
  p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.shift) |=> $stable(mosi));

endmodule

// File: rtl/spi_sel_master.sv
module spi_sel_master
  import spi_fm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [6:0]  csN
);

  logic [CTRL_W-1:0]   ctrlReg;
  logic [MAX_BITS-1:0] dataWord;
  xfer_strb_t          strb;

  spi_fm_ctrl #(
    .CLK_DIV(CLK_DIV)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .ctrlReg(ctrlReg),
    .busy   (busy),
    .sclk   (sclk),
    .csN    (csN),
    .strb   (strb)
  );

  spi_fm_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .busy    (busy),
    .strb    (strb),
    .miso    (miso),
    .mosi    (mosi),
    .dataWord(dataWord)
  );

  always_comb begin
    rdData = '0;
    if (addr == A_CTRL) begin
      rdData = ctrlReg;
    end
    if (addr == A_STAT) begin
      rdData = {7'b0, busy};
    end
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (addr == ADDR_W'(A_DATA0_I + k)) begin
        rdData = dataWord[8*k +: 8];
      end
    end
  end

  // R9: in automatic mode every select is released outside a frame
  p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ctrlReg[POS_MAN]) |-> (&csN));

  // R10: never more than one device selected
  p_cs_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

endmodule

// File: tb/spi_sel_master_tb.sv
module spi_sel_master_tb;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [2:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       busy;
  logic       sclk;
  logic       mosi;
  logic       miso;
  logic [6:0] csN;

  spi_sel_master u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always #5 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // behavioural slave and frame monitor
  bit          monOn = 1'b0;
  int          cyc, edges, firstEdge, lastEdge, badPeriod, sampCnt;
  int          busyCyc, busyFirst, csBad, frameBits;
  logic [31:0] slvWord, slvRx;
  logic [6:0]  expCs;
  logic        sampLvl, prevSclk;

  always_comb begin
    if (sampCnt < frameBits) miso = 1'(slvWord >> (frameBits - 1 - sampCnt));
    else miso = 1'b0;
  end

  always @(negedge clk) begin
    if (monOn) begin
      cyc++;
      if (busy) begin
        if (busyCyc == 0) busyFirst = cyc;
        busyCyc++;
        if (csN !== expCs) csBad++;
      end
      if (sclk !== prevSclk) begin
        edges++;
        if (edges == 1) firstEdge = cyc;
        else if (cyc - lastEdge != HALF) badPeriod++;
        lastEdge = cyc;
        if (sclk == sampLvl) begin
          slvRx = {slvRx[30:0], mosi};
          sampCnt++;
        end
      end
      prevSclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic rdWord(output logic [31:0] w);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(3'(k + 1), b);
      w[8*k +: 8] = b;
    end
  endtask

  // one frame: program, start, wait, then check pins and registers
  task automatic runXfer(input logic [7:0] cv, input logic [31:0] tx, input logic [31:0] sw,
                         input bit midWrite);
    int          n;
    logic [31:0] mask, got;
    logic [7:0]  st;
    n    = 8 * (int'(cv[5:4]) + 1);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    wr(3'd0, cv);
    frameBits = n; slvWord = sw; sampCnt = 0; slvRx = '0; edges = 0; badPeriod = 0;
    busyCyc = 0; busyFirst = 0; csBad = 0; cyc = 0; firstEdge = 0; lastEdge = 0;
    sampLvl = ~cv[6]; prevSclk = sclk;
    expCs = (cv[2:0] == 3'd0) ? 7'h7F : ~(7'd1 << (cv[2:0] - 3'd1));
    monOn = 1'b1;
    wr(3'd1, tx[7:0]);
    wr(3'd2, tx[15:8]);
    wr(3'd3, tx[23:16]);
    wr(3'd4, tx[31:24]);
    rd(3'd5, st);
    chk(st == 8'h01, "R7 status busy after start", 32'(st), 32'h1);
    if (midWrite) begin
      wr(3'd4, 8'hEE);
      wr(3'd1, 8'h77);
    end
    while (busy) @(negedge clk);
    monOn = 1'b0;
    chk(edges == 2 * n, "R4 sclk transitions per frame", 32'(edges), 32'(2 * n));
    chk((slvRx & mask) == (tx & mask), "R5 bits seen by slave", slvRx & mask, tx & mask);
    chk(badPeriod == 0, "R11 edge spacing", 32'(badPeriod), 32'h0);
    chk(firstEdge - busyFirst == HALF, "R9 lead before first edge",
        32'(firstEdge - busyFirst), 32'(HALF));
    chk(busyCyc == (2 * n + 1) * HALF, "R7 busy length", 32'(busyCyc), 32'((2 * n + 1) * HALF));
    chk(csBad == 0, "R9 select during frame", 32'(csBad), 32'h0);
    chk(sclk == cv[7], "R3 sclk back at rest", 32'(sclk), 32'(cv[7]));
    if (!cv[3]) chk(csN == 7'h7F, "R9 select released", 32'(csN), 32'h7F);
    rdWord(got);
    chk(got == ((tx & ~mask) | (sw & mask)), "R6 received data in registers",
        got, (tx & ~mask) | (sw & mask));
  endtask

  // {control, outgoing word, slave reply}
  localparam logic [71:0] VEC [8] = '{
    {8'h01, 32'h991122A5, 32'h0000003C},
    {8'h52, 32'h7700BEEF, 32'h00001234},
    {8'hA3, 32'h11C0FFEE, 32'h00ABCDEF},
    {8'hF7, 32'hDEADBEEF, 32'h13579BDF},
    {8'h35, 32'h80000001, 32'hFFFFFFFE},
    {8'hC4, 32'h55AA55AA, 32'h00000081},
    {8'h60, 32'h01234567, 32'h00F0F0F0},
    {8'h96, 32'hCAFE8001, 32'h00007FFE}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] w;
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    frameBits = 0; sampCnt = 0; slvWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk(v == 8'h00, "R1 control at reset", 32'(v), 32'h0);
    rdWord(w);   chk(w == 32'h0, "R1 data at reset", w, 32'h0);
    rd(3'd5, v); chk(v == 8'h00, "R1 status at reset", 32'(v), 32'h0);
    chk(busy == 1'b0 && sclk == 1'b0 && mosi == 1'b0, "R1 busy/sclk/mosi at reset",
        {29'b0, busy, sclk, mosi}, 32'h0);
    chk(csN == 7'h7F, "R1 selects at reset", 32'(csN), 32'h7F);

    // R2 readback, R3 idle level, R10 manual select
    wr(3'd0, 8'h5A); rd(3'd0, v); chk(v == 8'h5A, "R2 control readback", 32'(v), 32'h5A);
    chk(csN == 7'h7D, "R10 manual code 2", 32'(csN), 32'h7D);
    wr(3'd0, 8'hA5); rd(3'd0, v); chk(v == 8'hA5, "R2 control readback", 32'(v), 32'hA5);
    chk(sclk == 1'b1, "R3 idle high", 32'(sclk), 32'h1);
    chk(csN == 7'h7F, "R9 auto idle released", 32'(csN), 32'h7F);
    wr(3'd0, 8'h00); chk(sclk == 1'b0, "R3 idle low", 32'(sclk), 32'h0);
    wr(3'd0, 8'h0B); chk(csN == 7'h7B, "R10 manual code 3", 32'(csN), 32'h7B);
    wr(3'd0, 8'h0F); chk(csN == 7'h3F, "R10 manual code 7", 32'(csN), 32'h3F);
    wr(3'd0, 8'h08); chk(csN == 7'h7F, "R10 manual code 0", 32'(csN), 32'h7F);

    // table of frames across lengths, edges and selects
    for (int i = 0; i < 8; i++) begin
      runXfer(VEC[i][71:64], VEC[i][63:32], VEC[i][31:0], 1'b0);
    end

    // R10 manual-mode frame keeps the select afterwards
    runXfer(8'h0D, 32'h00000042, 32'h000000BD, 1'b0);
    chk(csN == 7'h6F, "R10 select held after frame", 32'(csN), 32'h6F);
    wr(3'd0, 8'h00);
    chk(csN == 7'h7F, "R10 select dropped by field", 32'(csN), 32'h7F);

    // R8 writes during a frame are ignored and do not restart it
    runXfer(8'h31, 32'hA1B2C3D4, 32'h0F1E2D3C, 1'b1);
    runXfer(8'h81, 32'h000000F0, 32'h0000000F, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule